// File: doc/BRIEF.md
# Quad DAC Code Bank

This block holds the digital codes for a four-channel digital-to-analog converter. Each channel keeps two levels of storage. The first is a staging register that the host fills ahead of time. The second is an active register whose value drives the converter core for that channel. A serial-command front end decodes bus traffic and hands the block one request at a time over a valid/ready handshake. A request can fill a staging register, promote staged data into the active register, or do both at once. A channel field selects one channel, or all four together.

Two asynchronous active-low board pins act on the bank without any bus traffic. The bulk-load pin promotes every staging register into its active register. The clear pin zeroes both register levels on all channels. It also tells the front end to abandon the bus transaction in progress, and it blocks new requests for a fixed guard interval after it is released.

Handshake rules: a request is taken on the rising clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` drops while clear is in effect, during the guard interval that follows it, and while a synchronized bulk load is active. While `cmd_ready` is low, the front end must hold its request steady.

Top module: `dac_code_bank`

## Requirements
- R1: While `rst_n` is low, every output code is zero, `cmd_abort` is high and `cmd_ready` is low.
- R2: Opcode 0 (stage) writes only the staging register of the selected channel(s). No output code changes at the accepting edge.
- R3: Opcode 1 (promote) copies the staging register into the active register for the selected channel(s). The other channels keep their output codes.
- R4: Opcode 2 (stage and promote) writes the new code into both the staging and the active register of the selected channel(s) at the accepting edge.
- R5: The channel field is 3 bits. Values 0 to 3 select that one channel. Any value with bit 2 set (4 to 7) selects all four channels.
- R6: The code is taken left-aligned from the 16-bit data word, `cmd_data[15:16-CODE_W]`. The lower bits are ignored.
- R7: `ldac_n` low passes through a two-flop synchronizer. From the third rising edge after it falls, each edge copies every staging register into its active register. `cmd_ready` is low while the synchronized load is active, so a load takes priority over a write.
- R8: `clr_n` low immediately zeroes all staging and active registers, without waiting for a clock. It raises `cmd_abort` and lowers `cmd_ready`. No request is accepted while clear is in effect.
- R9: After `clr_n` (or `rst_n`) rises, `cmd_abort` falls after the second rising edge. `cmd_ready` then stays low for `GUARD_CYCLES` further edges.
- R10: Opcode 3 is accepted and has no effect on any register.
- R11: A request presented while `cmd_ready` is low is held off and has no effect. It is taken on the first edge where `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Asynchronous active-low clear pin |
| ldac_n | input | 1 | Asynchronous active-low bulk-load pin |
| cmd_valid | input | 1 | Request valid |
| cmd_ready | output | 1 | Request ready |
| cmd_op | input | 2 | Opcode: 0 stage, 1 promote, 2 stage and promote, 3 none |
| cmd_chan | input | 3 | Channel select; bit 2 set selects all channels |
| cmd_data | input | 16 | Left-aligned code word |
| cmd_abort | output | 1 | Clear in effect; the front end drops its transaction |
| dac_code_o | output | NCH*CODE_W | Active codes; channel i is in bits [i*CODE_W +: CODE_W] |

## Verification
The assertions assume that the bulk-load and clear pins do not change during a request. They also assume that a request is only counted as taken when it is accepted while `cmd_abort` is low. The random stimulus therefore keeps both pins inactive. It varies only the valid line, opcode, channel and data on every cycle. Pin activity is exercised in directed sequences, where the bench sets the request lines itself and counts out the synchronizer and guard edges.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    OP_STAGE      = 2'd0,
    OP_PROMOTE    = 2'd1,
    OP_STAGE_PROM = 2'd2,
    OP_NONE       = 2'd3
  } dac_op_e;
endpackage

// File: rtl/dac_sync2.sv
module dac_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dac_clear_ctrl.sv
module dac_clear_ctrl #(
  parameter int GUARD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  output logic bank_rst_n,
  output logic abort,
  output logic guard_busy
);
  localparam int CNT_W = (GUARD_CYCLES < 1) ? 1 : $clog2(GUARD_CYCLES + 1);

  logic             any_clear_n;
  logic [CNT_W-1:0] guard_cnt;

  assign any_clear_n = rst_n & clr_n;

  // asynchronous assertion, release after two clock edges
  dac_sync2 #(.RST_VAL(1'b0)) u_rel (
    .clk    (clk),
    .arst_n (any_clear_n),
    .d      (1'b1),
    .q      (bank_rst_n)
  );

  always_ff @(posedge clk or negedge bank_rst_n) begin
    if (!bank_rst_n)
      guard_cnt <= CNT_W'(GUARD_CYCLES);
    else if (guard_cnt != '0)
      guard_cnt <= guard_cnt - 1'b1;
  end

  assign abort      = ~bank_rst_n;
  assign guard_busy = (guard_cnt != '0);
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_bank_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CODE_W = 12,
  localparam int CHW   = $clog2(NCH)
) (
  input  logic              fire,
  input  logic [1:0]        op,
  input  logic [CHW:0]      chan,
  input  logic [WORD_W-1:0] data,
  output logic [NCH-1:0]    stage_we,
  output logic [NCH-1:0]    prom_data,
  output logic [NCH-1:0]    prom_stage,
  output logic [CODE_W-1:0] code
);
  dac_op_e op_e;
  logic    unused_low_bits;

  assign op_e            = dac_op_e'(op);
  assign code            = data[WORD_W-1 -: CODE_W];
  assign unused_low_bits = ^data[WORD_W-1-CODE_W:0];

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    logic hit;
    assign hit           = fire && (chan[CHW] || (chan[CHW-1:0] == CHW'(i)));
    assign stage_we[i]   = hit && (op_e == OP_STAGE || op_e == OP_STAGE_PROM);
    assign prom_data[i]  = hit && (op_e == OP_STAGE_PROM);
    assign prom_stage[i] = hit && (op_e == OP_PROMOTE);
  end
endmodule

// File: rtl/dac_channel_reg.sv
module dac_channel_reg #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              stage_we,
  input  logic              prom_data,
  input  logic              prom_stage,
  input  logic              bulk_load,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] act_q
);
  logic [CODE_W-1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)
      stage_q <= '0;
    else if (stage_we && !bulk_load)
      stage_q <= din;
  end

  // bulk load wins over any request
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)
      act_q <= '0;
    else if (bulk_load)
      act_q <= stage_q;
    else if (prom_data)
      act_q <= din;
    else if (prom_stage)
      act_q <= stage_q;
  end
endmodule

// File: rtl/dac_code_bank.sv
module dac_code_bank
  import dac_bank_pkg::*;
#(
  parameter int NCH          = 4,
  parameter int CODE_W       = 12,
  parameter int GUARD_CYCLES = 4,
  localparam int CHW         = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_n,
  input  logic                  ldac_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [1:0]            cmd_op,
  input  logic [CHW:0]          cmd_chan,
  input  logic [WORD_W-1:0]     cmd_data,
  output logic                  cmd_abort,
  output logic [NCH*CODE_W-1:0] dac_code_o
);
  logic              bank_rst_n;
  logic              guard_busy;
  logic              load_act;
  logic              fire;
  logic [NCH-1:0]    stage_we;
  logic [NCH-1:0]    prom_data;
  logic [NCH-1:0]    prom_stage;
  logic [CODE_W-1:0] code;

  dac_clear_ctrl #(.GUARD_CYCLES(GUARD_CYCLES)) u_clr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_n      (clr_n),
    .bank_rst_n (bank_rst_n),
    .abort      (cmd_abort),
    .guard_busy (guard_busy)
  );

  dac_sync2 #(.RST_VAL(1'b0)) u_ldsync (
    .clk    (clk),
    .arst_n (rst_n),
    .d      (~ldac_n),
    .q      (load_act)
  );

  assign cmd_ready = bank_rst_n & ~guard_busy & ~load_act;
  assign fire      = cmd_valid & cmd_ready;

  dac_cmd_decode #(.NCH(NCH), .CODE_W(CODE_W)) u_dec (
    .fire       (fire),
    .op         (cmd_op),
    .chan       (cmd_chan),
    .data       (cmd_data),
    .stage_we   (stage_we),
    .prom_data  (prom_data),
    .prom_stage (prom_stage),
    .code       (code)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dac_channel_reg #(.CODE_W(CODE_W)) u_reg (
      .clk        (clk),
      .arst_n     (bank_rst_n),
      .stage_we   (stage_we[i]),
      .prom_data  (prom_data[i]),
      .prom_stage (prom_stage[i]),
      .bulk_load  (load_act),
      .din        (code),
      .act_q      (dac_code_o[i*CODE_W +: CODE_W])
    );
  end
endmodule

// File: rtl/dac_code_bank_chk.sv
module dac_code_bank_chk #(
  parameter int NCH    = 4,
  parameter int CODE_W = 12,
  localparam int CHW   = $clog2(NCH)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic                  cmd_ready,
  input logic [1:0]            cmd_op,
  input logic [CHW:0]          cmd_chan,
  input logic [15:0]           cmd_data,
  input logic                  cmd_abort,
  input logic [NCH*CODE_W-1:0] dac_code_o
);
  logic take;
  assign take = cmd_valid && cmd_ready;

  p_stage_only_r2: assert property (@(posedge clk) disable iff (!rst_n || cmd_abort)
    (take && cmd_op == 2'd0) |=> $stable(dac_code_o));

  p_none_op_r10: assert property (@(posedge clk) disable iff (!rst_n || cmd_abort)
    (take && cmd_op == 2'd3) |=> $stable(dac_code_o));

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    p_stage_prom_r4: assert property (@(posedge clk) disable iff (!rst_n || cmd_abort)
      (take && cmd_op == 2'd2 && (cmd_chan[CHW] || cmd_chan[CHW-1:0] == CHW'(i)))
      |=> dac_code_o[i*CODE_W +: CODE_W] == $past(cmd_data[15 -: CODE_W]));
  end

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |-> dac_code_o == '0);

  p_abort_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |-> !cmd_ready);

  p_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_abort) |-> !cmd_ready);
endmodule

bind dac_code_bank dac_code_bank_chk #(.NCH(NCH), .CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_op     (cmd_op),
  .cmd_chan   (cmd_chan),
  .cmd_data   (cmd_data),
  .cmd_abort  (cmd_abort),
  .dac_code_o (dac_code_o)
);

// File: tb/dac_code_bank_bench.sv
module dac_code_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CW  = 12;
  localparam int GUARD = 4;

  logic clk = 1'b0;
  logic rst_n, clr_n, ldac_n, cmd_valid, cmd_ready, cmd_abort;
  logic [1:0]  cmd_op;
  logic [2:0]  cmd_chan;
  logic [15:0] cmd_data;
  logic [NCH*CW-1:0] dac_code_o;

  int n_checks = 0;
  int n_fails  = 0;
  logic [CW-1:0] stg [NCH];
  logic [CW-1:0] act [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_code_bank #(.NCH(NCH), .CODE_W(CW), .GUARD_CYCLES(GUARD)) u_dac_code_bank (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ldac_n(ldac_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_chan(cmd_chan), .cmd_data(cmd_data), .cmd_abort(cmd_abort),
    .dac_code_o(dac_code_o)
  );

  function automatic logic [CW-1:0] code_of(logic [15:0] d);
    return d[15 -: CW];
  endfunction

  function automatic bit sel(logic [2:0] ch, int i);
    return ch[2] || (int'(ch[1:0]) == i);
  endfunction

  function automatic logic [NCH*CW-1:0] exp_vec();
    logic [NCH*CW-1:0] v;
    for (int i = 0; i < NCH; i++) v[i*CW +: CW] = act[i];
    return v;
  endfunction

  task automatic model_apply(logic [1:0] op, logic [2:0] ch, logic [15:0] d);
    for (int i = 0; i < NCH; i++) begin
      if (sel(ch, i)) begin
        case (op)
          2'd0: stg[i] = code_of(d);
          2'd1: act[i] = stg[i];
          2'd2: begin stg[i] = code_of(d); act[i] = code_of(d); end
          default: ;
        endcase
      end
    end
  endtask

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send(logic [1:0] op, logic [2:0] ch, logic [15:0] d);
    cmd_op = op; cmd_chan = ch; cmd_data = d; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    model_apply(op, ch, d);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NCH; i++) begin stg[i] = '0; act[i] = '0; end
    rst_n = 1'b0; clr_n = 1'b1; ldac_n = 1'b1;
    cmd_valid = 1'b0; cmd_op = 2'd0; cmd_chan = 3'd0; cmd_data = 16'h0;
    repeat (3) @(negedge clk);
    chk("R1 codes", 64'(dac_code_o), 64'(0));
    chk("R1 abort", 64'(cmd_abort), 64'(1));
    chk("R1 ready", 64'(cmd_ready), 64'(0));
    rst_n = 1'b1;
    repeat (2 + GUARD) @(negedge clk);
    chk("R9 ready after reset guard", 64'(cmd_ready), 64'(1));

    // R2: staging only
    send(2'd0, 3'd1, 16'h1230);
    chk("R2 stage leaves outputs", 64'(dac_code_o), 64'(exp_vec()));
    // R6 and R4
    send(2'd2, 3'd0, 16'hABCF);
    chk("R6 left aligned", 64'(dac_code_o[CW-1:0]), 64'(12'hABC));
    chk("R4 stage and promote", 64'(dac_code_o), 64'(exp_vec()));
    // R3 promote one channel
    send(2'd0, 3'd2, 16'h5A50);
    send(2'd1, 3'd2, 16'h0000);
    chk("R3 promote ch2", 64'(dac_code_o[2*CW +: CW]), 64'(12'h5A5));
    chk("R3 others kept", 64'(dac_code_o), 64'(exp_vec()));
    // R5 broadcast
    send(2'd2, 3'd5, 16'h7770);
    chk("R5 broadcast write+promote", 64'(dac_code_o), 64'(exp_vec()));
    send(2'd0, 3'd6, 16'h3C3F);
    send(2'd1, 3'd4, 16'h0000);
    chk("R5 broadcast promote", 64'(dac_code_o), 64'(exp_vec()));
    // R10 no-op
    send(2'd3, 3'd7, 16'hFFFF);
    chk("R10 no effect", 64'(dac_code_o), 64'(exp_vec()));

    // R7 bulk load pin
    send(2'd0, 3'd3, 16'h9990);
    send(2'd0, 3'd0, 16'h1110);
    ldac_n = 1'b0;
    @(negedge clk);
    chk("R7 ready before sync", 64'(cmd_ready), 64'(1));
    @(negedge clk);
    chk("R7 ready low during load", 64'(cmd_ready), 64'(0));
    chk("R7 not yet copied", 64'(dac_code_o), 64'(exp_vec()));
    @(negedge clk);
    for (int i = 0; i < NCH; i++) act[i] = stg[i];
    chk("R7 bulk copy", 64'(dac_code_o), 64'(exp_vec()));
    ldac_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 ready restored", 64'(cmd_ready), 64'(1));

    // R8 clear
    clr_n = 1'b0;
    #1;
    chk("R8 async zero", 64'(dac_code_o), 64'(0));
    chk("R8 abort", 64'(cmd_abort), 64'(1));
    chk("R8 ready low", 64'(cmd_ready), 64'(0));
    for (int i = 0; i < NCH; i++) begin stg[i] = '0; act[i] = '0; end
    @(negedge clk);
    cmd_op = 2'd2; cmd_chan = 3'd1; cmd_data = 16'hBEE0; cmd_valid = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 request ignored", 64'(dac_code_o), 64'(0));
    clr_n = 1'b1;
    @(negedge clk);
    chk("R9 abort held one edge", 64'(cmd_abort), 64'(1));
    @(negedge clk);
    chk("R9 abort fell", 64'(cmd_abort), 64'(0));
    chk("R9 guard ready low", 64'(cmd_ready), 64'(0));
    repeat (GUARD - 1) @(negedge clk);
    chk("R9 guard last cycle", 64'(cmd_ready), 64'(0));
    chk("R11 held request no effect", 64'(dac_code_o), 64'(0));
    @(negedge clk);
    chk("R11 ready after guard", 64'(cmd_ready), 64'(1));
    @(negedge clk);
    cmd_valid = 1'b0;
    model_apply(2'd2, 3'd1, 16'hBEE0);
    chk("R11 held request taken", 64'(dac_code_o), 64'(exp_vec()));
    // check the staging register was not written during clear: promote ch2
    send(2'd1, 3'd2, 16'h0);
    chk("R8 staging zeroed", 64'(dac_code_o), 64'(exp_vec()));

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] op;
      logic [2:0] ch;
      logic [15:0] d;
      logic v;
      op = 2'($urandom_range(0, 3));
      ch = 3'($urandom_range(0, 7));
      d  = 16'($urandom);
      v  = ($urandom_range(0, 3) != 0);
      cmd_op = op; cmd_chan = ch; cmd_data = d; cmd_valid = v;
      if (v && cmd_ready) model_apply(op, ch, d);
      @(negedge clk);
      chk("R2 R3 R4 R5 R6 R10 random", 64'(dac_code_o), 64'(exp_vec()));
    end
    cmd_valid = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule